// File: doc/BRIEF.md
# External Memory Access Sequencer

This block turns requests from an internal master into read and write cycles on an external parallel memory bus. It serves eight chip-select regions. Each region has its own base and mask for address matching, its own bus options and its own timing profile. Every control edge, every read-capture point, the access length and the idle gap are counted in cycles of the one functional clock. A per-access counter starts at zero when an access begins. Each active-low strobe is low while that counter lies inside the strobe's programmed window.

The internal master presents an address, write data, byte enables, a beat count, a direction and a valid. The block takes the request when it is ready. It returns each read word with a one-cycle valid pulse and ends the request with a done pulse. When the target region cannot burst, or is an 8-bit device, a multi-beat request becomes a string of single accesses. The address advances by one for each access, and the idle gap is inserted between them. A synchronised wait input can hold an access at its capture cycle. Configuration arrives on static input ports.

Top module: `memAccessSeq`

## Requirements
- R1: A request selects the lowest-numbered enabled region whose masked address equals its base. At most one chip-select line is low at any time, and only the selected one.
- R2: A request that matches no enabled region is taken at once. One cycle later, done and error pulse together, and no chip-select goes low.
- R3: Each access lasts the programmed length in cycles. Chip-select and output-enable are low exactly while the access counter n satisfies on <= n < off for their windows.
- R4: A read word is captured from the data input on the programmed capture cycle. It appears on the read-data port with a valid pulse in the next cycle, once per beat.
- R5: On a region that can burst and is not 8-bit, the beats of a request run back to back. There is no idle gap between them, the address stays at the start address, and address-valid is pulsed on the first beat only.
- R6: On a region that cannot burst, each beat is a single access. The address rises by one per beat, address-valid is pulsed every beat, and the idle gap separates the beats.
- R7: On an 8-bit region, requests always run as single accesses, as in R6. Read data keeps only bits 7:0, and the upper bits are zero.
- R8: On a multiplexed region, while address-valid is low, the data output carries the zero-extended address and the data output enable is high.
- R9: During a write, write-enable is low within its window, and the data output carries the write data with its enable high. Output-enable stays high.
- R10: The wait input passes through two flops. Wait is active when the synchronised level equals the region's polarity bit (1 = high means wait). With wait monitoring on, an active wait at the capture cycle holds the counter. With monitoring off, wait has no effect.
- R11: After the last beat of a request, the request port stays not-ready for the region's idle count of cycles.
- R12: The device clock-enable output is high while chip-select is low, if the region is set to synchronous for the current direction. Otherwise it is low.
- R13: Done pulses for one cycle, in the cycle after the last access cycle of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with valid |
| reqAddr | input | ADDR_W | Start address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data, taken at each beat start |
| reqBe | input | DATA_W/8 | Byte enables |
| reqLen | input | LEN_W | Beats minus one |
| rdValid | output | 1 | Read word valid pulse |
| rdData | output | DATA_W | Read word |
| rspDone | output | 1 | Request finished pulse |
| rspErr | output | 1 | Address matched no region |
| extCsN | output | NUM_CS | Chip-selects, active low |
| extAdvN | output | 1 | Address valid, active low |
| extOeN | output | 1 | Output enable, active low |
| extWeN | output | 1 | Write enable, active low |
| extBeN | output | DATA_W/8 | Byte enables, active low |
| extAddr | output | ADDR_W | Address bus |
| extDataOut | output | DATA_W | Data (or address in multiplexed phase) out |
| extDataOe | output | 1 | Drive enable for data out |
| extDataIn | input | DATA_W | Data from the device |
| extWait | input | 1 | Wait input, asynchronous |
| extClkEn | output | 1 | Device clock enable for synchronous access |
| cfgEnable | input | NUM_CS | Region enabled |
| cfgMuxed | input | NUM_CS | Address and data share the data pins |
| cfgBurstOk | input | NUM_CS | Region supports bursts |
| cfgNarrow | input | NUM_CS | Region is 8 bits wide |
| cfgWaitEn | input | NUM_CS | Wait monitoring on |
| cfgWaitPol | input | NUM_CS | Wait polarity, 1 = high means wait |
| cfgSyncRd | input | NUM_CS | Synchronous reads |
| cfgSyncWr | input | NUM_CS | Synchronous writes |
| cfgBase | input | NUM_CS*ADDR_W | Region base addresses |
| cfgMask | input | NUM_CS*ADDR_W | Region address masks |
| cfgCsOn | input | NUM_CS*CNT_W | Chip-select assert cycle |
| cfgCsOff | input | NUM_CS*CNT_W | Chip-select release cycle |
| cfgAdvOn | input | NUM_CS*CNT_W | Address-valid assert cycle |
| cfgAdvOff | input | NUM_CS*CNT_W | Address-valid release cycle |
| cfgOeOn | input | NUM_CS*CNT_W | Output-enable assert cycle |
| cfgOeOff | input | NUM_CS*CNT_W | Output-enable release cycle |
| cfgWeOn | input | NUM_CS*CNT_W | Write-enable assert cycle |
| cfgWeOff | input | NUM_CS*CNT_W | Write-enable release cycle |
| cfgCapture | input | NUM_CS*CNT_W | Read capture cycle |
| cfgLen | input | NUM_CS*CNT_W | Access length in cycles |
| cfgIdle | input | NUM_CS*CNT_W | Idle cycles after an access |

## Verification
The bench counts strobe-low cycles, beats, address-valid pulses and the cycles until done and ready for bursts, split bursts, 8-bit and multiplexed regions. A wrong lengths calculation, a missing idle gap between split beats, or a burst that re-pulses address-valid therefore shows up as a wrong count. An overlapping pair of regions catches a decoder that picks the higher index. An unmatched and a disabled address catch a decoder that starts a bus cycle anyway. A held wait catches an access that runs past an active wait. Wait driven high on a region with monitoring off catches a design that stalls when it should not.

// File: rtl/memSeqPkg.sv
package memSeqPkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ACCESS, SEQ_GAP} seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // request taken, latch address/data/enables
    logic nextBeat;  // a further beat starts, take new write data
    logic step;      // advance address for a split beat
    logic capture;   // capture read data this cycle
    logic csAct;
    logic advAct;
    logic oeAct;
    logic weAct;
    logic isWrite;
    logic muxed;
    logic narrow;
  } seqStrobe_t;
endpackage

// File: rtl/memSeqWaitSync.sv
module memSeqWaitSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[STAGES-2:0], din};
  end
  assign dout = shReg[STAGES-1];
endmodule

// File: rtl/memSeqCtrl.sv
module memSeqCtrl
  import memSeqPkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 4,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic                      reqWrite,
  input  logic [LEN_W-1:0]          reqLen,
  output logic                      reqReady,
  input  logic                      waitLevel,
  input  logic [NUM_CS-1:0]         cfgEnable,
  input  logic [NUM_CS-1:0]         cfgMuxed,
  input  logic [NUM_CS-1:0]         cfgBurstOk,
  input  logic [NUM_CS-1:0]         cfgNarrow,
  input  logic [NUM_CS-1:0]         cfgWaitEn,
  input  logic [NUM_CS-1:0]         cfgWaitPol,
  input  logic [NUM_CS-1:0]         cfgSyncRd,
  input  logic [NUM_CS-1:0]         cfgSyncWr,
  input  logic [NUM_CS*ADDR_W-1:0]  cfgBase,
  input  logic [NUM_CS*ADDR_W-1:0]  cfgMask,
  input  logic [NUM_CS*CNT_W-1:0]   cfgCsOn,
  input  logic [NUM_CS*CNT_W-1:0]   cfgCsOff,
  input  logic [NUM_CS*CNT_W-1:0]   cfgAdvOn,
  input  logic [NUM_CS*CNT_W-1:0]   cfgAdvOff,
  input  logic [NUM_CS*CNT_W-1:0]   cfgOeOn,
  input  logic [NUM_CS*CNT_W-1:0]   cfgOeOff,
  input  logic [NUM_CS*CNT_W-1:0]   cfgWeOn,
  input  logic [NUM_CS*CNT_W-1:0]   cfgWeOff,
  input  logic [NUM_CS*CNT_W-1:0]   cfgCapture,
  input  logic [NUM_CS*CNT_W-1:0]   cfgLen,
  input  logic [NUM_CS*CNT_W-1:0]   cfgIdle,
  output seqStrobe_t                strobe,
  output logic [NUM_CS-1:0]         extCsN,
  output logic                      extClkEn,
  output logic                      rspDone,
  output logic                      rspErr
);
  seqState_t         state;
  logic [CS_W-1:0]   csSel, hitIdx;
  logic [NUM_CS-1:0] hitVec;
  logic [CNT_W-1:0]  cnt, gapCnt;
  logic [LEN_W-1:0]  beatsLeft;
  logic              firstBeat, isWrite, splitMode, resumeAccess;

  function automatic logic [CNT_W-1:0] pick(input logic [NUM_CS*CNT_W-1:0] v,
                                            input logic [CS_W-1:0] s);
    return v[s*CNT_W +: CNT_W];
  endfunction

  function automatic logic inWin(input logic [CNT_W-1:0] n,
                                 input logic [CNT_W-1:0] on,
                                 input logic [CNT_W-1:0] off);
    return (n >= on) && (n < off);
  endfunction

  // address decode, one comparator per region
  for (genvar g = 0; g < NUM_CS; g++) begin : gDecode
    assign hitVec[g] = cfgEnable[g] &&
      ((reqAddr & cfgMask[g*ADDR_W +: ADDR_W]) == cfgBase[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (hitVec[i]) hitIdx = CS_W'(i);
  end

  logic [CNT_W-1:0] curLen, curCap, curIdle, lastCnt;
  logic inAccess, waitHold, beatEnd, take;
  assign curLen   = pick(cfgLen, csSel);
  assign curCap   = pick(cfgCapture, csSel);
  assign curIdle  = pick(cfgIdle, csSel);
  assign lastCnt  = curLen - CNT_W'(1);
  assign inAccess = (state == SEQ_ACCESS);
  assign waitHold = inAccess && cfgWaitEn[csSel] && (cnt == curCap) &&
                    (waitLevel == cfgWaitPol[csSel]);
  assign beatEnd  = inAccess && !waitHold && (cnt == lastCnt);
  assign reqReady = (state == SEQ_IDLE);
  assign take     = reqReady && reqValid;

  always_comb begin
    strobe          = '0;
    strobe.load     = take && (|hitVec);
    strobe.nextBeat = beatEnd && (beatsLeft != '0);
    strobe.step     = strobe.nextBeat && splitMode;
    strobe.capture  = inAccess && !isWrite && !waitHold && (cnt == curCap);
    strobe.csAct    = inAccess && inWin(cnt, pick(cfgCsOn, csSel), pick(cfgCsOff, csSel));
    strobe.advAct   = inAccess && (firstBeat || splitMode) &&
                      inWin(cnt, pick(cfgAdvOn, csSel), pick(cfgAdvOff, csSel));
    strobe.oeAct    = inAccess && !isWrite &&
                      inWin(cnt, pick(cfgOeOn, csSel), pick(cfgOeOff, csSel));
    strobe.weAct    = inAccess && isWrite &&
                      inWin(cnt, pick(cfgWeOn, csSel), pick(cfgWeOff, csSel));
    strobe.isWrite  = isWrite;
    strobe.muxed    = cfgMuxed[csSel];
    strobe.narrow   = cfgNarrow[csSel];
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gCs
    assign extCsN[g] = !(strobe.csAct && (csSel == CS_W'(g)));
  end

  assign extClkEn = strobe.csAct && (isWrite ? cfgSyncWr[csSel] : cfgSyncRd[csSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      csSel <= '0;
      cnt <= '0;
      gapCnt <= '0;
      beatsLeft <= '0;
      firstBeat <= 1'b0;
      isWrite <= 1'b0;
      splitMode <= 1'b0;
      resumeAccess <= 1'b0;
      rspDone <= 1'b0;
      rspErr <= 1'b0;
    end else begin
      rspDone <= 1'b0;
      rspErr  <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (take) begin
          if (|hitVec) begin
            state     <= SEQ_ACCESS;
            csSel     <= hitIdx;
            cnt       <= '0;
            beatsLeft <= reqLen;
            firstBeat <= 1'b1;
            isWrite   <= reqWrite;
            splitMode <= !cfgBurstOk[hitIdx] || cfgNarrow[hitIdx];
          end else begin
            rspDone <= 1'b1;
            rspErr  <= 1'b1;
          end
        end
        SEQ_ACCESS: if (!waitHold) begin
          if (cnt == lastCnt) begin
            cnt       <= '0;
            firstBeat <= 1'b0;
            if (beatsLeft == '0) begin
              rspDone      <= 1'b1;
              resumeAccess <= 1'b0;
              gapCnt       <= curIdle - CNT_W'(1);
              state        <= (curIdle != '0) ? SEQ_GAP : SEQ_IDLE;
            end else begin
              beatsLeft    <= beatsLeft - LEN_W'(1);
              resumeAccess <= 1'b1;
              gapCnt       <= curIdle - CNT_W'(1);
              if (splitMode && curIdle != '0) state <= SEQ_GAP;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        SEQ_GAP: begin
          if (gapCnt == '0) begin
            state <= resumeAccess ? SEQ_ACCESS : SEQ_IDLE;
            cnt   <= '0;
          end else begin
            gapCnt <= gapCnt - CNT_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~extCsN));
  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (&extCsN && rspDone));
  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    waitHold |=> (cnt == $past(cnt) && state == SEQ_ACCESS));
  assert_gap_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_GAP && gapCnt != '0) |=> (state == SEQ_GAP && !reqReady));
endmodule

// File: rtl/memSeqData.sv
module memSeqData
  import memSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOe,
  output logic              extAdvN,
  output logic              extOeN,
  output logic              extWeN,
  output logic [BE_W-1:0]   extBeN,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [BE_W-1:0]   beReg;
  logic              addrPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      beReg    <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        beReg    <= reqBe;
      end else begin
        if (strobe.step)     addrReg  <= addrReg + ADDR_W'(1);
        if (strobe.nextBeat) wdataReg <= reqWdata;
      end
      if (strobe.capture)
        rdData <= strobe.narrow ? {{(DATA_W-8){1'b0}}, extDataIn[7:0]} : extDataIn;
    end
  end

  assign addrPhase  = strobe.muxed && strobe.advAct;
  assign extAddr    = addrReg;
  assign extDataOut = addrPhase ? DATA_W'(addrReg) : wdataReg;
  assign extDataOe  = strobe.csAct && (strobe.isWrite || addrPhase);
  assign extAdvN    = !strobe.advAct;
  assign extOeN     = !strobe.oeAct;
  assign extWeN     = !strobe.weAct;
  assign extBeN     = strobe.csAct ? ~beReg : '1;

  assert_rd_after_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strobe.capture));
  assert_split_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (extAddr == ADDR_W'($past(extAddr) + ADDR_W'(1))));
  assert_oe_we_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(extOeN == 1'b0 && extWeN == 1'b0));
endmodule

// File: rtl/memAccessSeq.sv
module memAccessSeq
  import memSeqPkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWrite,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [BE_W-1:0]          reqBe,
  input  logic [LEN_W-1:0]         reqLen,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rspDone,
  output logic                     rspErr,
  output logic [NUM_CS-1:0]        extCsN,
  output logic                     extAdvN,
  output logic                     extOeN,
  output logic                     extWeN,
  output logic [BE_W-1:0]          extBeN,
  output logic [ADDR_W-1:0]        extAddr,
  output logic [DATA_W-1:0]        extDataOut,
  output logic                     extDataOe,
  input  logic [DATA_W-1:0]        extDataIn,
  input  logic                     extWait,
  output logic                     extClkEn,
  input  logic [NUM_CS-1:0]        cfgEnable,
  input  logic [NUM_CS-1:0]        cfgMuxed,
  input  logic [NUM_CS-1:0]        cfgBurstOk,
  input  logic [NUM_CS-1:0]        cfgNarrow,
  input  logic [NUM_CS-1:0]        cfgWaitEn,
  input  logic [NUM_CS-1:0]        cfgWaitPol,
  input  logic [NUM_CS-1:0]        cfgSyncRd,
  input  logic [NUM_CS-1:0]        cfgSyncWr,
  input  logic [NUM_CS*ADDR_W-1:0] cfgBase,
  input  logic [NUM_CS*ADDR_W-1:0] cfgMask,
  input  logic [NUM_CS*CNT_W-1:0]  cfgCsOn,
  input  logic [NUM_CS*CNT_W-1:0]  cfgCsOff,
  input  logic [NUM_CS*CNT_W-1:0]  cfgAdvOn,
  input  logic [NUM_CS*CNT_W-1:0]  cfgAdvOff,
  input  logic [NUM_CS*CNT_W-1:0]  cfgOeOn,
  input  logic [NUM_CS*CNT_W-1:0]  cfgOeOff,
  input  logic [NUM_CS*CNT_W-1:0]  cfgWeOn,
  input  logic [NUM_CS*CNT_W-1:0]  cfgWeOff,
  input  logic [NUM_CS*CNT_W-1:0]  cfgCapture,
  input  logic [NUM_CS*CNT_W-1:0]  cfgLen,
  input  logic [NUM_CS*CNT_W-1:0]  cfgIdle
);
  seqStrobe_t strobe;
  logic       waitLevel;

  memSeqWaitSync #(.STAGES(2)) uWaitSync (
    .clk(clk), .rstN(rstN), .din(extWait), .dout(waitLevel));

  memSeqCtrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqLen(reqLen), .reqReady(reqReady), .waitLevel(waitLevel),
    .cfgEnable(cfgEnable), .cfgMuxed(cfgMuxed), .cfgBurstOk(cfgBurstOk),
    .cfgNarrow(cfgNarrow), .cfgWaitEn(cfgWaitEn), .cfgWaitPol(cfgWaitPol),
    .cfgSyncRd(cfgSyncRd), .cfgSyncWr(cfgSyncWr), .cfgBase(cfgBase), .cfgMask(cfgMask),
    .cfgCsOn(cfgCsOn), .cfgCsOff(cfgCsOff), .cfgAdvOn(cfgAdvOn), .cfgAdvOff(cfgAdvOff),
    .cfgOeOn(cfgOeOn), .cfgOeOff(cfgOeOff), .cfgWeOn(cfgWeOn), .cfgWeOff(cfgWeOff),
    .cfgCapture(cfgCapture), .cfgLen(cfgLen), .cfgIdle(cfgIdle),
    .strobe(strobe), .extCsN(extCsN), .extClkEn(extClkEn),
    .rspDone(rspDone), .rspErr(rspErr));

  memSeqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .extDataIn(extDataIn), .extAddr(extAddr), .extDataOut(extDataOut),
    .extDataOe(extDataOe), .extAdvN(extAdvN), .extOeN(extOeN), .extWeN(extWeN),
    .extBeN(extBeN), .rdValid(rdValid), .rdData(rdData));
endmodule

// File: tb/memAccessSeq_test.sv
module memAccessSeq_test;
  localparam int NCS = 8, AW = 16, DW = 16, CW = 5, LW = 4;

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic [3:0]  len;
    logic [15:0] wdata;
    int          csIdx;   // expected region, -1 for error
    logic        split;
    logic        narrow;
    logic        muxed;
    logic        clkExp;
    int          expDone;
    int          expRdy;
    int          expCs;
    int          expAdv;
    int          expOe;
    int          expWe;
  } vec_t;

  localparam vec_t VECS[10] = '{
    '{16'h0040, 1'b0, 4'd0, 16'h0000,  0, 1'b0, 1'b0, 1'b0, 1'b1,  7,  8,  6, 1,  4, 0},
    '{16'h0100, 1'b0, 4'd3, 16'h0000,  0, 1'b0, 1'b0, 1'b0, 1'b1, 25, 26, 24, 1, 16, 0},
    '{16'h0200, 1'b1, 4'd0, 16'hBEEF,  0, 1'b0, 1'b0, 1'b0, 1'b0,  7,  8,  6, 1,  0, 3},
    '{16'h1010, 1'b0, 4'd0, 16'h0000,  1, 1'b1, 1'b0, 1'b1, 1'b0,  5,  7,  4, 1,  3, 0},
    '{16'h1020, 1'b0, 4'd2, 16'h0000,  1, 1'b1, 1'b0, 1'b1, 1'b0, 17, 19, 12, 3,  9, 0},
    '{16'h1030, 1'b1, 4'd1, 16'h1234,  1, 1'b1, 1'b0, 1'b1, 1'b1, 11, 13,  8, 2,  0, 4},
    '{16'h2005, 1'b0, 4'd2, 16'h0000,  2, 1'b1, 1'b1, 1'b0, 1'b0, 22, 25, 15, 3, 12, 0},
    '{16'h3000, 1'b0, 4'd0, 16'h0000, -1, 1'b0, 1'b0, 1'b0, 1'b0,  1,  1,  0, 0,  0, 0},
    '{16'hF000, 1'b1, 4'd0, 16'h5555, -1, 1'b0, 1'b0, 1'b0, 1'b0,  1,  1,  0, 0,  0, 0},
    '{16'h2100, 1'b1, 4'd0, 16'hCAFE,  2, 1'b1, 1'b1, 1'b0, 1'b0,  6,  9,  5, 1,  0, 3}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, extWait = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0] reqBe = 2'b11;
  logic [LW-1:0] reqLen = '0;
  logic reqReady, rdValid, rspDone, rspErr, extAdvN, extOeN, extWeN, extDataOe, extClkEn;
  logic [DW-1:0] rdData, extDataOut, extDataIn;
  logic [NCS-1:0] extCsN;
  logic [1:0] extBeN;
  logic [AW-1:0] extAddr;
  logic [NCS-1:0] cfgEnable, cfgMuxed, cfgBurstOk, cfgNarrow, cfgWaitEn, cfgWaitPol,
                  cfgSyncRd, cfgSyncWr;
  logic [NCS*AW-1:0] cfgBase, cfgMask;
  logic [NCS*CW-1:0] cfgCsOn, cfgCsOff, cfgAdvOn, cfgAdvOff, cfgOeOn, cfgOeOff,
                     cfgWeOn, cfgWeOff, cfgCapture, cfgLen, cfgIdle;

  always #10 clk = ~clk;
  assign extDataIn = extAddr ^ 16'hA5A5;

  memAccessSeq uut (.*);

  int total = 0, bad = 0, cycles = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic setCs(input int i, input logic en, input logic [15:0] base,
                       input logic mx, input logic bu, input logic nw, input logic we,
                       input logic pol, input logic sr, input logic sw,
                       input int csOn, input int csOff, input int advOn, input int advOff,
                       input int oeOn, input int oeOff, input int weOn, input int weOff,
                       input int cap, input int len, input int idle);
    cfgEnable[i] = en; cfgMuxed[i] = mx; cfgBurstOk[i] = bu; cfgNarrow[i] = nw;
    cfgWaitEn[i] = we; cfgWaitPol[i] = pol; cfgSyncRd[i] = sr; cfgSyncWr[i] = sw;
    cfgBase[i*AW +: AW] = base; cfgMask[i*AW +: AW] = 16'hF000;
    cfgCsOn[i*CW +: CW] = CW'(csOn);   cfgCsOff[i*CW +: CW] = CW'(csOff);
    cfgAdvOn[i*CW +: CW] = CW'(advOn); cfgAdvOff[i*CW +: CW] = CW'(advOff);
    cfgOeOn[i*CW +: CW] = CW'(oeOn);   cfgOeOff[i*CW +: CW] = CW'(oeOff);
    cfgWeOn[i*CW +: CW] = CW'(weOn);   cfgWeOff[i*CW +: CW] = CW'(weOff);
    cfgCapture[i*CW +: CW] = CW'(cap); cfgLen[i*CW +: CW] = CW'(len);
    cfgIdle[i*CW +: CW] = CW'(idle);
  endtask

  // issue one request and measure it at the ports
  task automatic runVec(input vec_t v);
    int n = 0, doneN = 0, rdyN = 0, csCnt = 0, wrongCs = 0, advCnt = 0, oeCnt = 0,
        weCnt = 0, rdCnt = 0, rdBad = 0, muxBad = 0, wrBad = 0, clkBad = 0, errSeen = 0;
    logic [15:0] expD;
    while (!reqReady) @(negedge clk);
    reqAddr = v.addr; reqWrite = v.wr; reqLen = v.len; reqWdata = v.wdata; reqValid = 1'b1;
    @(posedge clk);
    while (rdyN == 0 && n < 300) begin
      @(negedge clk);
      n++;
      reqValid = 1'b0;
      if (&extCsN == 1'b0) begin
        if (v.csIdx >= 0 && extCsN[v.csIdx] == 1'b0) csCnt++; else wrongCs++;
        if (extClkEn !== v.clkExp) clkBad++;
      end
      if (!extAdvN) begin
        advCnt++;
        if (v.muxed && (extDataOe !== 1'b1 || extDataOut !== extAddr)) muxBad++;
      end
      if (!extOeN) oeCnt++;
      if (!extWeN) begin
        weCnt++;
        if (extDataOe !== 1'b1 || extDataOut !== v.wdata) wrBad++;
      end
      if (rdValid) begin
        expD = (v.addr + (v.split ? 16'(rdCnt) : 16'd0)) ^ 16'hA5A5;
        if (v.narrow) expD = expD & 16'h00FF;
        if (rdData !== expD) rdBad++;
        rdCnt++;
      end
      if (rspDone && doneN == 0) begin doneN = n; errSeen = rspErr; end
      if (doneN != 0 && reqReady) rdyN = n;
    end
    check(doneN == v.expDone, "R13 done cycle", doneN, v.expDone);
    check(rdyN == v.expRdy, "R11 ready after idle", rdyN, v.expRdy);
    check(errSeen == (v.csIdx < 0), "R2 error flag", errSeen, v.csIdx < 0);
    check(csCnt == v.expCs, "R3 chip-select low cycles", csCnt, v.expCs);
    check(wrongCs == 0, "R1 wrong chip-select", wrongCs, 0);
    check(advCnt == v.expAdv, "R5/R6 address-valid pulses", advCnt, v.expAdv);
    check(oeCnt == v.expOe, "R3 output-enable cycles", oeCnt, v.expOe);
    check(weCnt == v.expWe && wrBad == 0, "R9 write strobe/data", weCnt, v.expWe);
    check(rdCnt == (v.wr || v.csIdx < 0 ? 0 : int'(v.len) + 1), "R4 read beats",
          rdCnt, v.wr ? 0 : int'(v.len) + 1);
    check(rdBad == 0, "R4/R7 read data", rdBad, 0);
    check(muxBad == 0, "R8 multiplexed address phase", muxBad, 0);
    check(clkBad == 0, "R12 device clock enable", clkBad, 0);
  endtask

  initial begin
    cfgEnable = '0; cfgMuxed = '0; cfgBurstOk = '0; cfgNarrow = '0; cfgWaitEn = '0;
    cfgWaitPol = '0; cfgSyncRd = '0; cfgSyncWr = '0; cfgBase = '0; cfgMask = '0;
    cfgCsOn = '0; cfgCsOff = '0; cfgAdvOn = '0; cfgAdvOff = '0; cfgOeOn = '0;
    cfgOeOff = '0; cfgWeOn = '0; cfgWeOff = '0; cfgCapture = '0; cfgLen = '0; cfgIdle = '0;
    for (int i = 0; i < NCS; i++)
      setCs(i, 1'b0, 16'hE000, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0);
    //     idx en  base    mx bu nw we pl sr sw csOn/Off adv   oe    we   cap len idle
    setCs(0, 1, 16'h0000, 0, 1, 0, 0, 0, 1, 0, 0, 6, 0, 1, 2, 6, 2, 5, 5, 6, 1);
    setCs(1, 1, 16'h1000, 1, 0, 0, 1, 1, 0, 1, 0, 4, 0, 1, 1, 4, 1, 3, 3, 4, 2);
    setCs(2, 1, 16'h2000, 0, 1, 1, 0, 0, 0, 0, 0, 5, 0, 1, 1, 5, 1, 4, 4, 5, 3);
    setCs(3, 0, 16'h3000, 0, 1, 0, 0, 0, 0, 0, 0, 5, 0, 1, 1, 5, 1, 4, 4, 5, 1);
    setCs(4, 1, 16'h2000, 0, 1, 0, 0, 0, 0, 0, 0, 3, 0, 1, 1, 3, 1, 2, 2, 3, 1);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && &extCsN && !rspDone && !rdValid && extOeN && extWeN && extAdvN,
          "R13 reset state", {reqReady, extCsN}, 9'h1FF);

    foreach (VECS[k]) runVec(VECS[k]);

    // R10: wait high on a region with monitoring off changes nothing
    extWait = 1'b1;
    repeat (4) @(negedge clk);
    runVec(VECS[0]);

    // R10: wait held on region 1 (polarity high) stalls the access at capture
    begin
      int n = 0, doneN = 0;
      logic sawDone = 1'b0;
      while (!reqReady) @(negedge clk);
      reqAddr = 16'h1044; reqWrite = 1'b0; reqLen = '0; reqValid = 1'b1;
      @(posedge clk);
      repeat (30) begin
        @(negedge clk);
        reqValid = 1'b0;
        if (rspDone) sawDone = 1'b1;
      end
      check(!sawDone && extCsN[1] == 1'b0, "R10 access held by wait", sawDone, 0);
      extWait = 1'b0;
      while (doneN == 0 && n < 20) begin
        @(negedge clk);
        n++;
        if (rdValid) check(rdData == (16'h1044 ^ 16'hA5A5), "R10 read after wait",
                           rdData, 16'h1044 ^ 16'hA5A5);
        if (rspDone) doneN = n;
      end
      check(doneN >= 3 && doneN <= 5, "R10 release after sync", doneN, 4);
    end

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule